// File: doc/BRIEF.md
# Parallel Load/Store Extension Executor

This block runs the extension operation that rides in the low byte of a 16-bit instruction word, next to the main operation of a small signal processor. A start strobe hands it the byte. The block then drives the data-memory ports and the register-file ports. It also sends per-pointer update requests (decrement, increment, or add the matching index register) to an external address unit. The address unit owns the four address pointers and their index registers and returns the current pointer values. Extension operations never touch the program counter, and this block has no path to it.

Each operation runs in a main phase, which is the cycle after the strobe. The combined store-and-load group also has an epilogue phase one cycle later. In that group the store and its pointer update happen in the main phase. The load, its register write and its pointer update are deferred to the epilogue. The pointer pair is fixed: pointer 0 and pointer 3. A `done` strobe marks the last cycle of every operation.

Register codes on the register-file ports are 3 bits wide:

| Code | Register |
|------|----------|
| 0 | input register 0, low word |
| 1 | input register 1, low word |
| 2 | input register 0, high word |
| 3 | input register 1, high word |
| 4 | accumulator 0, low word |
| 5 | accumulator 1, low word |
| 6 | accumulator 0, middle word |
| 7 | accumulator 1, middle word |

Update request codes are 2 bits per pointer:

| Code | Request |
|------|---------|
| 00 | none |
| 01 | decrement |
| 10 | increment |
| 11 | add index |

Top module: `xop_engine`

## Requirements
- R1: After reset, and at any time while `busy` is low, `busy`, `done`, every memory and register enable and all of `upd_req` are 0.
- R2: A `go` seen while the block is idle captures `op_byte`. `busy` is 1 in the next cycle. For every byte outside the 10xx_xxxx group, `done` is 1 in that same cycle and `busy` is 0 in the cycle after.
- R3: Byte 0000_ffpp with ff not 00 requests update code ff on pointer pp and leaves memory and registers unchanged. Bytes 0000_00xx change nothing. Updates wrap modulo 2^AW.
- R4: Byte 0001_ddss writes register code {0,dd} with the value of register code {1,ss}.
- R5: Byte 001s_snpp stores register code {1,ss} to the address in pointer pp. It then requests increment on pp when n=0, or add index when n=1.
- R6: Byte 01dd_dnpp loads register code ddd from the address in pointer pp. It requests increment on pp when n=0, or add index when n=1.
- R7: Byte 10dd_xyks stores register code {1,1,s}. When k=0 the store goes through pointer 3 and the load through pointer 0. When k=1 the store goes through pointer 0 and the load through pointer 3. Pointer 3 gets add index when x=1 and increment otherwise. Pointer 0 gets add index when y=1 and increment otherwise.
- R8: For the 10xx_xxxx group, only the store and the store pointer's update happen in the main phase. The load into register code {0,dd} and the load pointer's update happen one cycle later, with `done`. A load from the same address therefore returns the value just stored.
- R9: Byte 11dr_mnpp loads register code {0,d,0} from pointer pp and register code {0,r,1} from pointer 3, in the same cycle. Pointer pp gets add index when n=1 and increment otherwise. Pointer 3 gets add index when m=1 and increment otherwise.
- R10: In the 11xx_xxxx group with pp=3, both loads read through pointer 3, and pointer 3 receives a single request chosen by m alone.
- R11: A `go` that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start strobe |
| op_byte | input | 8 | Extension byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of the operation |
| ptr_val | input | 4*AW | Current pointer values, pointer 0 in the low bits |
| upd_req | output | 8 | Update code per pointer, pointer 0 in bits 1:0 |
| rf_rd_sel | output | 3 | Register code to read |
| rf_rd_data | input | DW | Value of the selected register |
| mem_we | output | 1 | Data-memory write enable |
| mem_waddr | output | AW | Write address |
| mem_wdata | output | DW | Write data |
| mem_re_a | output | 1 | Read port A enable |
| mem_raddr_a | output | AW | Read port A address |
| mem_rdata_a | input | DW | Read port A data, same cycle |
| mem_re_b | output | 1 | Read port B enable |
| mem_raddr_b | output | AW | Read port B address (pointer 3) |
| mem_rdata_b | input | DW | Read port B data, same cycle |
| rf_we_a | output | 1 | Register write port A enable |
| rf_wsel_a | output | 3 | Port A register code |
| rf_wdata_a | output | DW | Port A data |
| rf_we_b | output | 1 | Register write port B enable |
| rf_wsel_b | output | 3 | Port B register code |
| rf_wdata_b | output | DW | Port B data |

## Verification
The bench builds the block with AW=8 and DW=16, so the pointer space covers exactly the 256-word memory model. Random pointers and index values then reach wrap-around on every update kind. Fully random bytes reach every decode group, including the pointer-3 merge case. At that width, pointer 0 and pointer 3 can easily be made equal, which exposes whether the deferred load really sees the store made in the main phase.

// File: rtl/xop_pkg.sv
package xop_pkg;

   localparam int NPTR = 4;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_MAIN = 2'd1,
      PH_EPI  = 2'd2
   } phase_t;

   localparam logic [1:0] UPD_NONE = 2'b00;
   localparam logic [1:0] UPD_DEC  = 2'b01;
   localparam logic [1:0] UPD_INC  = 2'b10;
   localparam logic [1:0] UPD_IDX  = 2'b11;

   // control for one phase of an extension operation
   typedef struct packed {
      logic                  st_en;
      logic [1:0]            st_ptr;
      logic [2:0]            src_sel;
      logic                  mv_en;
      logic                  la_en;
      logic [1:0]            la_ptr;
      logic [2:0]            a_dst;
      logic                  lb_en;
      logic [2:0]            lb_dst;
      logic [NPTR-1:0][1:0]  upd;
   } ctl_t;

   function automatic logic [1:0] upd_step(input logic use_idx);
      return use_idx ? UPD_IDX : UPD_INC;
   endfunction

endpackage

// File: rtl/xop_decode.sv
module xop_decode
   import xop_pkg::*;
(
   input  logic [7:0] op,
   output ctl_t       ctl_main,
   output ctl_t       ctl_epi,
   output logic       has_epi
);

   logic [1:0] st_p;
   logic [1:0] ld_p;

   assign has_epi = (op[7:6] == 2'b10);
   assign st_p    = op[1] ? 2'd0 : 2'd3;
   assign ld_p    = op[1] ? 2'd3 : 2'd0;

   always_comb begin
      ctl_main = '0;
      ctl_epi  = '0;
      priority casez (op)
         8'b0000_00??: ;
         8'b0000_????: begin
            ctl_main.upd[op[1:0]] = op[3:2];
         end
         8'b0001_????: begin
            ctl_main.mv_en   = 1'b1;
            ctl_main.src_sel = {1'b1, op[1:0]};
            ctl_main.a_dst   = {1'b0, op[3:2]};
         end
         8'b001?_????: begin
            ctl_main.st_en        = 1'b1;
            ctl_main.st_ptr       = op[1:0];
            ctl_main.src_sel      = {1'b1, op[4:3]};
            ctl_main.upd[op[1:0]] = upd_step(op[2]);
         end
         8'b01??_????: begin
            ctl_main.la_en        = 1'b1;
            ctl_main.la_ptr       = op[1:0];
            ctl_main.a_dst        = op[5:3];
            ctl_main.upd[op[1:0]] = upd_step(op[2]);
         end
         8'b10??_????: begin
            ctl_main.st_en     = 1'b1;
            ctl_main.st_ptr    = st_p;
            ctl_main.src_sel   = {2'b11, op[0]};
            ctl_main.upd[st_p] = (st_p == 2'd3) ? upd_step(op[3]) : upd_step(op[2]);
            ctl_epi.la_en      = 1'b1;
            ctl_epi.la_ptr     = ld_p;
            ctl_epi.a_dst      = {1'b0, op[5:4]};
            ctl_epi.upd[ld_p]  = (ld_p == 2'd3) ? upd_step(op[3]) : upd_step(op[2]);
         end
         default: begin
            ctl_main.la_en        = 1'b1;
            ctl_main.la_ptr       = op[1:0];
            ctl_main.a_dst        = {1'b0, op[5], 1'b0};
            ctl_main.lb_en        = 1'b1;
            ctl_main.lb_dst       = {1'b0, op[4], 1'b1};
            ctl_main.upd[op[1:0]] = upd_step(op[2]);
            // pointer 3 request set last so it wins when both name pointer 3
            ctl_main.upd[3]       = upd_step(op[3]);
         end
      endcase
   end

endmodule

// File: rtl/xop_phase.sv
module xop_phase
   import xop_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   go,
   input  logic   has_epi,
   output phase_t phase,
   output logic   take,
   output logic   busy,
   output logic   done
);

   phase_t phase_nx;

   assign take = go && (phase == PH_IDLE);
   assign busy = (phase != PH_IDLE);
   assign done = ((phase == PH_MAIN) && !has_epi) || (phase == PH_EPI);

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE: if (go) phase_nx = PH_MAIN;
         PH_MAIN: phase_nx = has_epi ? PH_EPI : PH_IDLE;
         PH_EPI:  phase_nx = PH_IDLE;
         default: phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nx;
   end

endmodule

// File: rtl/xop_route.sv
module xop_route
   import xop_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  ctl_t                 ctl,
   input  logic [NPTR*AW-1:0]   ptr_val,
   input  logic [DW-1:0]        rf_rd_data,
   input  logic [DW-1:0]        mem_rdata_a,
   input  logic [DW-1:0]        mem_rdata_b,
   output logic [2*NPTR-1:0]    upd_req,
   output logic [2:0]           rf_rd_sel,
   output logic                 mem_we,
   output logic [AW-1:0]        mem_waddr,
   output logic [DW-1:0]        mem_wdata,
   output logic                 mem_re_a,
   output logic [AW-1:0]        mem_raddr_a,
   output logic                 mem_re_b,
   output logic [AW-1:0]        mem_raddr_b,
   output logic                 rf_we_a,
   output logic [2:0]           rf_wsel_a,
   output logic [DW-1:0]        rf_wdata_a,
   output logic                 rf_we_b,
   output logic [2:0]           rf_wsel_b,
   output logic [DW-1:0]        rf_wdata_b
);

   localparam int PAIR_PTR = NPTR - 1;

   logic [AW-1:0] ptr_arr [NPTR];

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      assign ptr_arr[g]        = ptr_val[g*AW +: AW];
      assign upd_req[2*g +: 2] = ctl.upd[g];
   end

   assign rf_rd_sel   = ctl.src_sel;
   assign mem_we      = ctl.st_en;
   assign mem_waddr   = ptr_arr[ctl.st_ptr];
   assign mem_wdata   = rf_rd_data;

   assign mem_re_a    = ctl.la_en;
   assign mem_raddr_a = ptr_arr[ctl.la_ptr];
   assign rf_we_a     = ctl.la_en | ctl.mv_en;
   assign rf_wsel_a   = ctl.a_dst;
   assign rf_wdata_a  = ctl.mv_en ? rf_rd_data : mem_rdata_a;

   assign mem_re_b    = ctl.lb_en;
   assign mem_raddr_b = ptr_arr[PAIR_PTR];
   assign rf_we_b     = ctl.lb_en;
   assign rf_wsel_b   = ctl.lb_dst;
   assign rf_wdata_b  = mem_rdata_b;

endmodule

// File: rtl/xop_engine.sv
module xop_engine
   import xop_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [7:0]        op_byte,
   output logic              busy,
   output logic              done,
   input  logic [4*AW-1:0]   ptr_val,
   output logic [7:0]        upd_req,
   output logic [2:0]        rf_rd_sel,
   input  logic [DW-1:0]     rf_rd_data,
   output logic              mem_we,
   output logic [AW-1:0]     mem_waddr,
   output logic [DW-1:0]     mem_wdata,
   output logic              mem_re_a,
   output logic [AW-1:0]     mem_raddr_a,
   input  logic [DW-1:0]     mem_rdata_a,
   output logic              mem_re_b,
   output logic [AW-1:0]     mem_raddr_b,
   input  logic [DW-1:0]     mem_rdata_b,
   output logic              rf_we_a,
   output logic [2:0]        rf_wsel_a,
   output logic [DW-1:0]     rf_wdata_a,
   output logic              rf_we_b,
   output logic [2:0]        rf_wsel_b,
   output logic [DW-1:0]     rf_wdata_b
);

   if (AW < 2) begin : g_aw_bad
      $error("xop_engine: AW must be at least 2");
   end
   if (DW < 2) begin : g_dw_bad
      $error("xop_engine: DW must be at least 2");
   end

   logic [7:0] op_q;
   phase_t     phase;
   logic       take;
   logic       has_epi;
   ctl_t       ctl_main;
   ctl_t       ctl_epi;
   ctl_t       ctl_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    op_q <= '0;
      else if (take) op_q <= op_byte;
   end

   xop_decode i_dec (
      .op       (op_q),
      .ctl_main (ctl_main),
      .ctl_epi  (ctl_epi),
      .has_epi  (has_epi)
   );

   xop_phase i_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .has_epi (has_epi),
      .phase   (phase),
      .take    (take),
      .busy    (busy),
      .done    (done)
   );

   always_comb begin
      unique case (phase)
         PH_MAIN: ctl_sel = ctl_main;
         PH_EPI:  ctl_sel = ctl_epi;
         default: ctl_sel = '0;
      endcase
   end

   xop_route #(.AW(AW), .DW(DW)) i_route (
      .ctl         (ctl_sel),
      .ptr_val     (ptr_val),
      .rf_rd_data  (rf_rd_data),
      .mem_rdata_a (mem_rdata_a),
      .mem_rdata_b (mem_rdata_b),
      .upd_req     (upd_req),
      .rf_rd_sel   (rf_rd_sel),
      .mem_we      (mem_we),
      .mem_waddr   (mem_waddr),
      .mem_wdata   (mem_wdata),
      .mem_re_a    (mem_re_a),
      .mem_raddr_a (mem_raddr_a),
      .mem_re_b    (mem_re_b),
      .mem_raddr_b (mem_raddr_b),
      .rf_we_a     (rf_we_a),
      .rf_wsel_a   (rf_wsel_a),
      .rf_wdata_a  (rf_wdata_a),
      .rf_we_b     (rf_we_b),
      .rf_wsel_b   (rf_wsel_b),
      .rf_wdata_b  (rf_wdata_b)
   );

endmodule

// File: rtl/xop_engine_chk.sv
module xop_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic       mem_we,
   input logic       mem_re_a,
   input logic       mem_re_b,
   input logic       rf_we_a,
   input logic       rf_we_b,
   input logic [7:0] upd_req
);

   logic [3:0] act;

   always_comb begin
      for (int i = 0; i < 4; i++) act[i] = |upd_req[2*i +: 2];
   end

   // R2
   done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R8
   epi_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && done));

   // R11
   idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!(mem_we || mem_re_a || mem_re_b || rf_we_a || rf_we_b) && (upd_req == 8'h00)));

   // R9
   dual_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_b |-> (rf_we_a && mem_re_a && mem_re_b));

   // R7
   store_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !(rf_we_a || rf_we_b));

   // R3
   ptr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(act) <= 2);

endmodule

bind xop_engine xop_engine_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .mem_we   (mem_we),
   .mem_re_a (mem_re_a),
   .mem_re_b (mem_re_b),
   .rf_we_a  (rf_we_a),
   .rf_we_b  (rf_we_b),
   .upd_req  (upd_req)
);

// File: tb/test_xop_engine.sv
`timescale 1ns/1ps
module test_xop_engine;

   localparam int AW = 8;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go = 1'b0;
   logic [7:0] op_byte = 8'h00;
   logic busy, done;
   logic [4*AW-1:0] ptr_val;
   logic [7:0] upd_req;
   logic [2:0] rf_rd_sel;
   logic [DW-1:0] rf_rd_data;
   logic mem_we;
   logic [AW-1:0] mem_waddr;
   logic [DW-1:0] mem_wdata;
   logic mem_re_a;
   logic [AW-1:0] mem_raddr_a;
   logic [DW-1:0] mem_rdata_a;
   logic mem_re_b;
   logic [AW-1:0] mem_raddr_b;
   logic [DW-1:0] mem_rdata_b;
   logic rf_we_a;
   logic [2:0] rf_wsel_a;
   logic [DW-1:0] rf_wdata_a;
   logic rf_we_b;
   logic [2:0] rf_wsel_b;
   logic [DW-1:0] rf_wdata_b;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   logic [DW-1:0] m_mem [256];
   logic [DW-1:0] e_mem [256];
   logic [DW-1:0] m_reg [8];
   logic [DW-1:0] e_reg [8];
   logic [AW-1:0] m_ptr [4];
   logic [AW-1:0] e_ptr [4];
   logic [AW-1:0] idx   [4];

   always #2.5 clk = ~clk;

   xop_engine #(.AW(AW), .DW(DW)) i_xop_engine (
      .clk(clk), .rst_n(rst_n), .go(go), .op_byte(op_byte),
      .busy(busy), .done(done), .ptr_val(ptr_val), .upd_req(upd_req),
      .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .mem_re_a(mem_re_a), .mem_raddr_a(mem_raddr_a), .mem_rdata_a(mem_rdata_a),
      .mem_re_b(mem_re_b), .mem_raddr_b(mem_raddr_b), .mem_rdata_b(mem_rdata_b),
      .rf_we_a(rf_we_a), .rf_wsel_a(rf_wsel_a), .rf_wdata_a(rf_wdata_a),
      .rf_we_b(rf_we_b), .rf_wsel_b(rf_wsel_b), .rf_wdata_b(rf_wdata_b)
   );

   assign ptr_val     = {m_ptr[3], m_ptr[2], m_ptr[1], m_ptr[0]};
   assign rf_rd_data  = m_reg[rf_rd_sel];
   assign mem_rdata_a = m_mem[mem_raddr_a];
   assign mem_rdata_b = m_mem[mem_raddr_b];

   function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p, input logic [1:0] c,
                                              input logic [AW-1:0] ix);
      case (c)
         2'b01:   return p - 1'b1;
         2'b10:   return p + 1'b1;
         2'b11:   return p + ix;
         default: return p;
      endcase
   endfunction

   // environment: memory, register file and address unit
   always @(posedge clk) begin
      if (mem_we)  m_mem[mem_waddr] <= mem_wdata;
      if (rf_we_a) m_reg[rf_wsel_a] <= rf_wdata_a;
      if (rf_we_b) m_reg[rf_wsel_b] <= rf_wdata_b;
      for (int i = 0; i < 4; i++)
         m_ptr[i] <= step_ptr(m_ptr[i], upd_req[2*i +: 2], idx[i]);
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string r, input string what,
                      input int act, input int exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [7:0] o);
      if (o[7:4] == 4'b0000) return "R3";
      if (o[7:4] == 4'b0001) return "R4";
      if (o[7:5] == 3'b001)  return "R5";
      if (o[7:6] == 2'b01)   return "R6";
      if (o[7:6] == 2'b10)   return "R7_R8";
      if (o[1:0] == 2'd3)    return "R10";
      return "R9";
   endfunction

   task automatic e_upd(input int p, input logic [1:0] c);
      e_ptr[p] = step_ptr(e_ptr[p], c, idx[p]);
   endtask

   // reference: expected effect of one extension byte
   task automatic ref_op(input logic [7:0] o);
      int st, ld, ss;
      logic [DW-1:0] va, vb;
      ss = int'(o[1:0]);
      if (o[7:2] == 6'b000000) begin
      end else if (o[7:4] == 4'b0000) begin
         e_upd(ss, o[3:2]);
      end else if (o[7:4] == 4'b0001) begin
         e_reg[{1'b0, o[3:2]}] = e_reg[{1'b1, o[1:0]}];
      end else if (o[7:5] == 3'b001) begin
         e_mem[e_ptr[ss]] = e_reg[{1'b1, o[4:3]}];
         e_upd(ss, o[2] ? 2'b11 : 2'b10);
      end else if (o[7:6] == 2'b01) begin
         e_reg[o[5:3]] = e_mem[e_ptr[ss]];
         e_upd(ss, o[2] ? 2'b11 : 2'b10);
      end else if (o[7:6] == 2'b10) begin
         st = o[1] ? 0 : 3;
         ld = o[1] ? 3 : 0;
         e_mem[e_ptr[st]] = e_reg[{2'b11, o[0]}];
         e_upd(st, (st == 3) ? (o[3] ? 2'b11 : 2'b10) : (o[2] ? 2'b11 : 2'b10));
         e_reg[{1'b0, o[5:4]}] = e_mem[e_ptr[ld]];
         e_upd(ld, (ld == 3) ? (o[3] ? 2'b11 : 2'b10) : (o[2] ? 2'b11 : 2'b10));
      end else begin
         va = e_mem[e_ptr[ss]];
         vb = e_mem[e_ptr[3]];
         e_reg[{1'b0, o[5], 1'b0}] = va;
         e_reg[{1'b0, o[4], 1'b1}] = vb;
         if (ss != 3) e_upd(ss, o[2] ? 2'b11 : 2'b10);
         e_upd(3, o[3] ? 2'b11 : 2'b10);
      end
   endtask

   task automatic compare(input string r, input logic [7:0] o);
      int errs = 0;
      string where = "";
      int act = 0, exp = 0;
      for (int i = 0; i < 256; i++)
         if (m_mem[i] !== e_mem[i]) begin
            if (errs == 0) begin where = $sformatf("mem[%0d]", i); act = m_mem[i]; exp = e_mem[i]; end
            errs++;
         end
      for (int i = 0; i < 8; i++)
         if (m_reg[i] !== e_reg[i]) begin
            if (errs == 0) begin where = $sformatf("reg[%0d]", i); act = m_reg[i]; exp = e_reg[i]; end
            errs++;
         end
      for (int i = 0; i < 4; i++)
         if (m_ptr[i] !== e_ptr[i]) begin
            if (errs == 0) begin where = $sformatf("ptr[%0d]", i); act = m_ptr[i]; exp = e_ptr[i]; end
            errs++;
         end
      chk(errs == 0, r, $sformatf("state after op %02h at %s", o, where), act, exp);
      for (int i = 0; i < 256; i++) e_mem[i] = m_mem[i];
      for (int i = 0; i < 8; i++) e_reg[i] = m_reg[i];
      for (int i = 0; i < 4; i++) e_ptr[i] = m_ptr[i];
   endtask

   task automatic set_ptr(input int p, input logic [AW-1:0] v);
      @(negedge clk);
      m_ptr[p] = v;
      e_ptr[p] = v;
   endtask

   // hold_go keeps go high through the main phase with another byte (R11)
   task automatic run_op(input logic [7:0] o, input bit hold_go);
      bit two;
      two = (o[7:6] == 2'b10);
      ref_op(o);
      @(negedge clk);
      go = 1'b1;
      op_byte = o;
      @(negedge clk);
      if (hold_go) op_byte = 8'h0F;
      else go = 1'b0;
      chk(busy == 1'b1, "R2", "busy in main phase", busy, 1);
      chk(done == !two, two ? "R8" : "R2", "done in main phase", done, !two);
      if (two) begin
         @(negedge clk);
         go = 1'b0;
         chk(busy && done, "R8", "busy&done in epilogue", {busy, done}, 3);
      end
      @(negedge clk);
      go = 1'b0;
      chk(busy == 1'b0, hold_go ? "R11" : "R2", "busy after op", busy, 0);
      compare(hold_go ? "R11" : req_of(o), o);
   endtask

   initial begin
      void'($urandom(32'd1357));
      for (int i = 0; i < 256; i++) begin m_mem[i] = DW'($urandom); e_mem[i] = m_mem[i]; end
      for (int i = 0; i < 8; i++) begin m_reg[i] = DW'($urandom); e_reg[i] = m_reg[i]; end
      for (int i = 0; i < 4; i++) begin
         m_ptr[i] = AW'($urandom); e_ptr[i] = m_ptr[i]; idx[i] = AW'($urandom);
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, mem_we, mem_re_a, mem_re_b, rf_we_a, rf_we_b} == 7'b0, "R1",
          "enables after reset", {busy, done, mem_we, mem_re_a, mem_re_b, rf_we_a, rf_we_b}, 0);
      chk(upd_req == 8'h00, "R1", "upd_req after reset", upd_req, 0);

      // R3 no-op, decrement with wrap, increment, index add
      run_op(8'h00, 1'b0);
      run_op(8'h03, 1'b0);
      set_ptr(1, '0);
      run_op(8'h05, 1'b0);
      chk(m_ptr[1] == 8'hFF, "R3", "decrement wrap", m_ptr[1], 8'hFF);
      run_op(8'h0A, 1'b0);
      run_op(8'h0F, 1'b0);
      // R4 move, R5 store, R6 load
      run_op(8'h1B, 1'b0);
      run_op(8'h29, 1'b0);
      run_op(8'h36, 1'b0);
      run_op(8'h5E, 1'b0);
      run_op(8'h7D, 1'b0);
      // R8 same address for store and deferred load
      set_ptr(0, 8'h40);
      set_ptr(3, 8'h40);
      run_op(8'h80, 1'b0);
      chk(m_reg[0] == m_reg[6], "R8", "load sees main-phase store", m_reg[0], m_reg[6]);
      set_ptr(0, 8'h22);
      set_ptr(3, 8'h22);
      run_op(8'hBF, 1'b0);
      run_op(8'h96, 1'b0);
      // R9 dual load, R10 pointer 3 merge
      run_op(8'hC1, 1'b0);
      run_op(8'hEE, 1'b0);
      run_op(8'hCF, 1'b0);
      run_op(8'hF3, 1'b0);
      // R11 go held during busy
      run_op(8'h88, 1'b1);
      run_op(8'h44, 1'b1);
      // random mix
      for (int n = 0; n < 500; n++) begin
         if (($urandom % 8) == 0) set_ptr(0, m_ptr[3]);
         run_op(8'($urandom), ($urandom % 16) == 0);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule